// File: doc/BRIEF.md
# Configurable USB Endpoint Packet FIFO

This block buffers byte data for one USB device endpoint. It sits between a host-side data port and a USB packet engine. The host side uses a single data port: each write strobe stores one byte for the IN direction, and each read strobe removes one byte from the OUT direction. The engine side pushes OUT packets, pops IN packets and signals when a packet is ready and when it has been consumed. Both sides share one fixed-size byte buffer.

Four configuration inputs set how the buffer is used. With split off, the whole buffer forms one FIFO, and a direction input says whether that FIFO carries IN or OUT traffic. With split on, the buffer is cut into two equal halves: the low half serves IN and the high half serves OUT. Each active FIFO can run single-buffered, holding one packet, or double-buffered. In double-buffered mode it holds two packets, each up to half the size. One side can then fill a packet while the other side drains the previous one.

Bytes that would break the size or slot rules are dropped and raise a sticky overrun flag. Reads with nothing valid return zero and raise a sticky underrun flag. Any change of configuration empties the block and clears both flags.

Top module: `ep_fifo`

## Requirements
- R1: After reset, `hst_rdata` and `eng_in_rdata` are 0x00, `hst_out_rdy` and `eng_in_rdy` are 0, and both sticky flags are 0.
- R2: Each `hst_wr` stores exactly one byte into the IN FIFO. After `hst_commit`, `eng_in_rdy` is 1, `eng_in_rdata` shows the oldest unread byte, each `eng_in_rd` advances by exactly one byte in write order, and `eng_in_done` releases the packet.
- R3: Each `eng_out_wr` stores one byte into the OUT FIFO. After `eng_out_commit`, `hst_out_rdy` is 1, `hst_rdata` shows the oldest unread byte, each `hst_rd` removes exactly one byte, and `hst_done` releases the packet.
- R4: With split on and single buffering, each direction accepts packets of up to BUF_BYTES/2 bytes (256 at the default).
- R5: With split off, one FIFO of BUF_BYTES (512 at the default, single-buffered) serves the direction chosen by `cfg_out_dir` (0 = IN, 1 = OUT). Writes to the other direction are dropped and set the overrun flag. Reads from the other direction return 0x00 and set the underrun flag.
- R6: With double buffering, a FIFO holds up to two committed packets, each at most half the single-buffered limit. The producer may fill the second packet while the first is still unconsumed. Packets are consumed in commit order.
- R7: With split on, `cfg_dbl_in` controls double buffering of IN and `cfg_dbl_out` controls double buffering of OUT, each independently of the other.
- R8: With split off, `cfg_dbl_in` alone selects double buffering for the single FIFO, which limits packets to BUF_BYTES/2 bytes. `cfg_dbl_out` has no effect in this case.
- R9: A write is dropped, and sets the sticky overrun flag, when no packet slot is free or when the packet being built has already reached the size limit.
- R10: A read with no unread byte in a ready packet returns 0x00, leaves the read position unchanged and sets the sticky underrun flag.
- R11: Any change of the four configuration inputs, seen at a clock edge, drops all stored and pending data in both directions, clears both flags and ignores that cycle's strobes.
- R12: A commit with no bytes is ignored. A write in the same cycle as its commit is included in the packet. A done signal discards any unread bytes of the head packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_split | input | 1 | 1 = separate IN and OUT halves |
| cfg_dbl_in | input | 1 | Double buffering for IN (or for the whole FIFO when unsplit) |
| cfg_dbl_out | input | 1 | Double buffering for OUT when split |
| cfg_out_dir | input | 1 | Unsplit direction: 0 = IN, 1 = OUT |
| hst_wr | input | 1 | Data-port write: store one IN byte |
| hst_wdata | input | 8 | Byte to store |
| hst_commit | input | 1 | Mark the IN packet being built as ready |
| hst_rd | input | 1 | Data-port read: remove one OUT byte |
| hst_rdata | output | 8 | Oldest unread OUT byte, or 0x00 |
| hst_done | input | 1 | Release the head OUT packet |
| hst_out_rdy | output | 1 | An OUT packet is ready |
| eng_out_wr | input | 1 | Engine stores one OUT byte |
| eng_out_wdata | input | 8 | Byte to store |
| eng_out_commit | input | 1 | Mark the OUT packet being built as ready |
| eng_in_rd | input | 1 | Engine removes one IN byte |
| eng_in_rdata | output | 8 | Oldest unread IN byte, or 0x00 |
| eng_in_done | input | 1 | Release the head IN packet |
| eng_in_rdy | output | 1 | An IN packet is ready |
| ovr_flag | output | 1 | Sticky overrun |
| und_flag | output | 1 | Sticky underrun |

## Verification
The hardest case to reach is a double-buffered FIFO with both slots full while the consumer is partway through the older packet. Only in that case do the slot-swap rule and the "no free slot" drop interact with a same-cycle commit or done. The stimulus gets there by committing two maximum-size packets back to back, then trying a third. After that comes a long stretch of random, concurrent strobes on both sides of a split, double-buffered configuration. A queue-based model follows packets by count and offset and is compared with the outputs on every cycle.

// File: rtl/epf_pkg.sv
package epf_pkg;
  // configuration as seen by the block; a change of any field flushes it
  typedef struct packed {
    logic out_dir;
    logic dbl_out;
    logic dbl_in;
    logic split;
  } epf_cfg_t;
endpackage

// File: rtl/epf_mem.sv
module epf_mem #(
  parameter int BUF_BYTES = 512
) (
  input  logic                         clk,
  input  logic                         we_a,
  input  logic [$clog2(BUF_BYTES)-1:0] wa_a,
  input  logic [7:0]                   wd_a,
  input  logic                         we_b,
  input  logic [$clog2(BUF_BYTES)-1:0] wa_b,
  input  logic [7:0]                   wd_b,
  input  logic [$clog2(BUF_BYTES)-1:0] ra_a,
  output logic [7:0]                   rd_a,
  input  logic [$clog2(BUF_BYTES)-1:0] ra_b,
  output logic [7:0]                   rd_b
);
  logic [7:0] store [BUF_BYTES];

  // the two write ports never target one address: unsplit mode keeps one side idle
  always_ff @(posedge clk) begin
    if (we_a) store[wa_a] <= wd_a;
    if (we_b) store[wa_b] <= wd_b;
  end

  assign rd_a = store[ra_a];
  assign rd_b = store[ra_b];
endmodule

// File: rtl/epf_ctl.sv
module epf_ctl #(
  parameter int BUF_BYTES = 512
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         act,
  input  logic                         half,
  input  logic                         dbl,
  input  logic [$clog2(BUF_BYTES)-1:0] base,
  input  logic                         wr,
  input  logic                         commit,
  input  logic                         rd,
  input  logic                         done,
  output logic                         wr_ok,
  output logic [$clog2(BUF_BYTES)-1:0] waddr,
  output logic [$clog2(BUF_BYTES)-1:0] raddr,
  output logic                         rvalid,
  output logic                         pkt_rdy,
  output logic                         ovr_evt,
  output logic                         und_evt
);
  localparam int AW = $clog2(BUF_BYTES);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] WHOLE = CW'(BUF_BYTES);

  logic          wslot_q, wslot_n, rslot_q, rslot_n;
  logic [CW-1:0] wcnt_q, wcnt_n, roff_q, roff_n;
  logic [CW-1:0] len_q [2];
  logic [CW-1:0] len_n [2];
  logic [1:0]    full_q, full_n;

  logic [CW-1:0] region, mx, wcnt_add;
  logic [AW-1:0] wofs, rofs;
  logic          com_ok, done_ok;

  always_comb begin
    region   = half ? (WHOLE >> 1) : WHOLE;
    mx       = dbl ? (region >> 1) : region;
    wofs     = wslot_q ? mx[AW-1:0] : '0;
    rofs     = rslot_q ? mx[AW-1:0] : '0;
    wr_ok    = act && wr && !full_q[wslot_q] && (wcnt_q < mx);
    ovr_evt  = wr && !wr_ok;
    wcnt_add = wcnt_q + CW'(wr_ok);
    com_ok   = act && commit && !full_q[wslot_q] && (wcnt_add != '0);
    pkt_rdy  = full_q[rslot_q];
    rvalid   = pkt_rdy && (roff_q < len_q[rslot_q]);
    und_evt  = rd && !rvalid;
    done_ok  = done && pkt_rdy;
    waddr    = base + wofs + wcnt_q[AW-1:0];
    raddr    = base + rofs + roff_q[AW-1:0];
  end

  always_comb begin
    wslot_n = wslot_q;
    rslot_n = rslot_q;
    wcnt_n  = wcnt_q;
    roff_n  = roff_q;
    len_n   = len_q;
    full_n  = full_q;
    if (flush) begin
      wslot_n  = 1'b0;
      rslot_n  = 1'b0;
      wcnt_n   = '0;
      roff_n   = '0;
      full_n   = '0;
      len_n[0] = '0;
      len_n[1] = '0;
    end else begin
      wcnt_n = wcnt_add;
      roff_n = roff_q + CW'(rd && rvalid);
      if (com_ok) begin
        full_n[wslot_q] = 1'b1;
        len_n[wslot_q]  = wcnt_add;
        wcnt_n          = '0;
        wslot_n         = dbl ? ~wslot_q : wslot_q;
      end
      if (done_ok) begin
        full_n[rslot_q] = 1'b0;
        roff_n          = '0;
        rslot_n         = dbl ? ~rslot_q : rslot_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wslot_q  <= 1'b0;
      rslot_q  <= 1'b0;
      wcnt_q   <= '0;
      roff_q   <= '0;
      full_q   <= '0;
      len_q[0] <= '0;
      len_q[1] <= '0;
    end else begin
      wslot_q <= wslot_n;
      rslot_q <= rslot_n;
      wcnt_q  <= wcnt_n;
      roff_q  <= roff_n;
      full_q  <= full_n;
      len_q   <= len_n;
    end
  end
endmodule

// File: rtl/ep_fifo.sv
module ep_fifo #(
  parameter int BUF_BYTES = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_split,
  input  logic       cfg_dbl_in,
  input  logic       cfg_dbl_out,
  input  logic       cfg_out_dir,
  input  logic       hst_wr,
  input  logic [7:0] hst_wdata,
  input  logic       hst_commit,
  input  logic       hst_rd,
  output logic [7:0] hst_rdata,
  input  logic       hst_done,
  output logic       hst_out_rdy,
  input  logic       eng_out_wr,
  input  logic [7:0] eng_out_wdata,
  input  logic       eng_out_commit,
  input  logic       eng_in_rd,
  output logic [7:0] eng_in_rdata,
  input  logic       eng_in_done,
  output logic       eng_in_rdy,
  output logic       ovr_flag,
  output logic       und_flag
);
  import epf_pkg::*;
  localparam int AW = $clog2(BUF_BYTES);
  localparam logic [AW-1:0] HI_BASE = AW'(BUF_BYTES / 2);

  epf_cfg_t      cfg_now, cfg_q;
  logic          flush;
  logic          in_act, out_act, out_dbl;
  logic [AW-1:0] out_base;
  logic          in_wok, out_wok, in_rv, out_rv;
  logic          in_ovr, out_ovr, in_und, out_und;
  logic [AW-1:0] in_wa, in_ra, out_wa, out_ra;
  logic [7:0]    in_byte, out_byte;
  logic          ovr_q, ovr_n, und_q, und_n;

  always_comb begin
    cfg_now  = '{out_dir: cfg_out_dir, dbl_out: cfg_dbl_out,
                 dbl_in: cfg_dbl_in, split: cfg_split};
    flush    = (cfg_now != cfg_q);
    in_act   = cfg_q.split || !cfg_q.out_dir;
    out_act  = cfg_q.split || cfg_q.out_dir;
    out_dbl  = cfg_q.split ? cfg_q.dbl_out : cfg_q.dbl_in;
    out_base = cfg_q.split ? HI_BASE : '0;
    ovr_n    = flush ? 1'b0 : (ovr_q || in_ovr || out_ovr);
    und_n    = flush ? 1'b0 : (und_q || in_und || out_und);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      ovr_q <= 1'b0;
      und_q <= 1'b0;
    end else begin
      cfg_q <= cfg_now;
      ovr_q <= ovr_n;
      und_q <= und_n;
    end
  end

  epf_ctl #(.BUF_BYTES(BUF_BYTES)) u_in_ctl (
    .clk(clk), .rst_n(rst_n), .flush(flush), .act(in_act),
    .half(cfg_q.split), .dbl(cfg_q.dbl_in), .base('0),
    .wr(hst_wr), .commit(hst_commit), .rd(eng_in_rd), .done(eng_in_done),
    .wr_ok(in_wok), .waddr(in_wa), .raddr(in_ra), .rvalid(in_rv),
    .pkt_rdy(eng_in_rdy), .ovr_evt(in_ovr), .und_evt(in_und)
  );

  epf_ctl #(.BUF_BYTES(BUF_BYTES)) u_out_ctl (
    .clk(clk), .rst_n(rst_n), .flush(flush), .act(out_act),
    .half(cfg_q.split), .dbl(out_dbl), .base(out_base),
    .wr(eng_out_wr), .commit(eng_out_commit), .rd(hst_rd), .done(hst_done),
    .wr_ok(out_wok), .waddr(out_wa), .raddr(out_ra), .rvalid(out_rv),
    .pkt_rdy(hst_out_rdy), .ovr_evt(out_ovr), .und_evt(out_und)
  );

  epf_mem #(.BUF_BYTES(BUF_BYTES)) u_mem (
    .clk(clk),
    .we_a(in_wok && !flush),  .wa_a(in_wa),  .wd_a(hst_wdata),
    .we_b(out_wok && !flush), .wa_b(out_wa), .wd_b(eng_out_wdata),
    .ra_a(in_ra), .rd_a(in_byte), .ra_b(out_ra), .rd_b(out_byte)
  );

  assign eng_in_rdata = in_rv  ? in_byte  : 8'h00;
  assign hst_rdata    = out_rv ? out_byte : 8'h00;
  assign ovr_flag     = ovr_q;
  assign und_flag     = und_q;
endmodule

// File: rtl/ep_fifo_chk.sv
module ep_fifo_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       flush,
  input logic       hst_rd,
  input logic       hst_done,
  input logic [7:0] hst_rdata,
  input logic       hst_out_rdy,
  input logic       eng_in_rdy,
  input logic       ovr_flag,
  input logic       und_flag
);
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_rd && !hst_out_rdy) |-> (hst_rdata == 8'h00)); // R10

  AST_UNDERRUN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_rd && !hst_out_rdy && !flush) |=> und_flag); // R10

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !flush) |=> ovr_flag); // R9

  AST_UND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (und_flag && !flush) |=> und_flag); // R10

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!hst_out_rdy && !eng_in_rdy && !ovr_flag && !und_flag)); // R11

  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_out_rdy && !hst_rd && !hst_done && !flush) |=> $stable(hst_rdata)); // R3
endmodule

bind ep_fifo ep_fifo_chk u_ep_fifo_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .hst_rd(hst_rd),
  .hst_done(hst_done), .hst_rdata(hst_rdata), .hst_out_rdy(hst_out_rdy),
  .eng_in_rdy(eng_in_rdy), .ovr_flag(ovr_flag), .und_flag(und_flag)
);

// File: tb/test_ep_fifo.sv
module test_ep_fifo;
  localparam int BUF = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_split = 0, cfg_dbl_in = 0, cfg_dbl_out = 0, cfg_out_dir = 0;
  logic hst_wr = 0, hst_commit = 0, hst_rd = 0, hst_done = 0;
  logic [7:0] hst_wdata = 0, eng_out_wdata = 0;
  logic eng_out_wr = 0, eng_out_commit = 0, eng_in_rd = 0, eng_in_done = 0;
  logic [7:0] hst_rdata, eng_in_rdata;
  logic hst_out_rdy, eng_in_rdy, ovr_flag, und_flag;

  always #4 clk = ~clk;

  ep_fifo #(.BUF_BYTES(BUF)) i_ep_fifo (
    .clk(clk), .rst_n(rst_n), .cfg_split(cfg_split), .cfg_dbl_in(cfg_dbl_in),
    .cfg_dbl_out(cfg_dbl_out), .cfg_out_dir(cfg_out_dir),
    .hst_wr(hst_wr), .hst_wdata(hst_wdata), .hst_commit(hst_commit),
    .hst_rd(hst_rd), .hst_rdata(hst_rdata), .hst_done(hst_done),
    .hst_out_rdy(hst_out_rdy), .eng_out_wr(eng_out_wr),
    .eng_out_wdata(eng_out_wdata), .eng_out_commit(eng_out_commit),
    .eng_in_rd(eng_in_rd), .eng_in_rdata(eng_in_rdata),
    .eng_in_done(eng_in_done), .eng_in_rdy(eng_in_rdy),
    .ovr_flag(ovr_flag), .und_flag(und_flag)
  );

  int n_run = 0, n_fail = 0;
  string tag = "R1";
  bit ended = 0;

  // behavioural model: direction 0 = IN, 1 = OUT
  int m_pend [2][$];
  int m_data [2][$];
  int m_lens [2][$];
  int m_off [2];
  bit m_ovr, m_und;
  logic [3:0] m_cfg;

  task automatic m_clear();
    for (int d = 0; d < 2; d++) begin
      m_pend[d].delete(); m_data[d].delete(); m_lens[d].delete(); m_off[d] = 0;
    end
    m_ovr = 0; m_und = 0;
  endtask

  task automatic m_dir(int d, bit act, int mx, int slots, bit wr, int wd,
                       bit com, bit rd, bit dn);
    int pre_n;
    bit v;
    pre_n = m_lens[d].size();
    v = (pre_n > 0) && (m_off[d] < m_lens[d][0]);
    if (wr) begin
      if (act && pre_n < slots && m_pend[d].size() < mx) m_pend[d].push_back(wd);
      else m_ovr = 1;
    end
    if (act && com && pre_n < slots && m_pend[d].size() > 0) begin
      m_lens[d].push_back(m_pend[d].size());
      foreach (m_pend[d][i]) m_data[d].push_back(m_pend[d][i]);
      m_pend[d].delete();
    end
    if (rd) begin
      if (v) m_off[d]++;
      else m_und = 1;
    end
    if (dn && pre_n > 0) begin
      repeat (m_lens[d][0]) void'(m_data[d].pop_front());
      void'(m_lens[d].pop_front());
      m_off[d] = 0;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_clear();
      m_cfg = 4'b0;
    end else if ({cfg_out_dir, cfg_dbl_out, cfg_dbl_in, cfg_split} != m_cfg) begin
      m_clear();
      m_cfg = {cfg_out_dir, cfg_dbl_out, cfg_dbl_in, cfg_split};
    end else begin
      int reg_sz, mx_in, mx_out;
      bit dbo;
      reg_sz = cfg_split ? BUF / 2 : BUF;
      dbo    = cfg_split ? cfg_dbl_out : cfg_dbl_in;
      mx_in  = cfg_dbl_in ? reg_sz / 2 : reg_sz;
      mx_out = dbo ? reg_sz / 2 : reg_sz;
      m_dir(0, cfg_split || !cfg_out_dir, mx_in, cfg_dbl_in ? 2 : 1,
            hst_wr, hst_wdata, hst_commit, eng_in_rd, eng_in_done);
      m_dir(1, cfg_split || cfg_out_dir, mx_out, dbo ? 2 : 1,
            eng_out_wr, eng_out_wdata, eng_out_commit, hst_rd, hst_done);
    end
  end

  task automatic chk(string r, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", r, what, act, exp, $time);
    end
  endtask

  function automatic int exp_rdata(int d);
    if (m_lens[d].size() > 0 && m_off[d] < m_lens[d][0]) return m_data[d][m_off[d]];
    return 0;
  endfunction

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      chk(tag, "eng_in_rdata", int'(eng_in_rdata), exp_rdata(0));
      chk(tag, "hst_rdata", int'(hst_rdata), exp_rdata(1));
      chk(tag, "eng_in_rdy", int'(eng_in_rdy), int'(m_lens[0].size() > 0));
      chk(tag, "hst_out_rdy", int'(hst_out_rdy), int'(m_lens[1].size() > 0));
      chk(tag, "ovr_flag", int'(ovr_flag), int'(m_ovr));
      chk(tag, "und_flag", int'(und_flag), int'(m_und));
    end
  end

  task automatic step();
    @(negedge clk);
    hst_wr = 0; hst_commit = 0; hst_rd = 0; hst_done = 0;
    eng_out_wr = 0; eng_out_commit = 0; eng_in_rd = 0; eng_in_done = 0;
  endtask

  task automatic set_cfg(bit s, bit bi, bit bo, bit od);
    cfg_split = s; cfg_dbl_in = bi; cfg_dbl_out = bo; cfg_out_dir = od;
    step(); step();
  endtask

  task automatic h_write(int n, int seed);
    for (int i = 0; i < n; i++) begin hst_wr = 1; hst_wdata = 8'(seed + i * 7); step(); end
  endtask
  task automatic h_commit(); hst_commit = 1; step(); endtask
  task automatic e_write(int n, int seed);
    for (int i = 0; i < n; i++) begin eng_out_wr = 1; eng_out_wdata = 8'(seed + i * 3); step(); end
  endtask
  task automatic e_commit(); eng_out_commit = 1; step(); endtask
  task automatic e_read(int n);
    for (int i = 0; i < n; i++) begin eng_in_rd = 1; step(); end
  endtask
  task automatic h_read(int n);
    for (int i = 0; i < n; i++) begin hst_rd = 1; step(); end
  endtask
  task automatic e_done(); eng_in_done = 1; step(); endtask
  task automatic h_done(); hst_done = 1; step(); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    // R1: reset state
    tag = "R1";
    chk("R1", "hst_rdata", int'(hst_rdata), 0);
    chk("R1", "eng_in_rdata", int'(eng_in_rdata), 0);
    chk("R1", "rdy", int'(hst_out_rdy | eng_in_rdy), 0);
    chk("R1", "flags", int'(ovr_flag | und_flag), 0);

    // R2: IN path, split single-buffered
    tag = "R2"; set_cfg(1, 0, 0, 0);
    h_write(5, 17); h_commit();
    chk("R2", "eng_in_rdy", int'(eng_in_rdy), 1);
    chk("R2", "first byte", int'(eng_in_rdata), 17);
    e_read(5); e_done();
    // R3: OUT path
    tag = "R3";
    e_write(4, 90); e_commit();
    chk("R3", "first byte", int'(hst_rdata), 90);
    h_read(2);
    chk("R3", "third byte", int'(hst_rdata), 96);
    h_read(2); h_done();

    // R4: split single limit 256, R9 overrun on the extra bytes
    tag = "R4";
    h_write(260, 1);
    chk("R9", "ovr_flag", int'(ovr_flag), 1);
    h_commit(); e_read(256);
    chk("R4", "eng_in_rdata after 256", int'(eng_in_rdata), 0);
    e_done();
    e_write(256, 5); e_write(1, 0); e_commit(); h_read(256); h_done();

    // R7: IN double, OUT single, independently
    tag = "R7"; set_cfg(1, 1, 0, 0);
    h_write(129, 3); h_commit();           // R6: 128-byte limit
    chk("R6", "ovr_flag", int'(ovr_flag), 1);
    h_write(128, 40); h_commit();          // second slot while first pending
    h_write(1, 0);                         // R9: no free slot
    e_read(10); e_done();                  // R6: commit order
    chk("R6", "second pkt head", int'(eng_in_rdata), 40);
    e_read(128); e_done();
    e_write(256, 9); e_commit(); e_write(1, 1);
    chk("R7", "out one slot", int'(ovr_flag), 1);
    h_read(256); h_done();

    // R5: unsplit IN, 512 limit; OUT side inactive
    tag = "R5"; set_cfg(0, 0, 1, 0);
    h_write(513, 11); h_commit();
    chk("R5", "ovr 513th", int'(ovr_flag), 1);
    h_read(1);
    chk("R5", "inactive read", int'(hst_rdata), 0);
    e_write(1, 1); e_read(512); e_done();
    set_cfg(0, 0, 0, 1);
    e_write(512, 2); e_commit(); h_read(512); h_done();

    // R8: unsplit double via cfg_dbl_in
    tag = "R8"; set_cfg(0, 1, 0, 1);
    e_write(257, 4); e_commit();
    chk("R8", "ovr 257th", int'(ovr_flag), 1);
    e_write(256, 8); e_commit(); e_write(3, 0);
    h_read(256); h_done(); h_read(256); h_done();

    // R10: empty reads, read past the end
    tag = "R10"; set_cfg(1, 0, 0, 0);
    h_read(1);
    chk("R10", "und_flag", int'(und_flag), 1);
    chk("R10", "empty data", int'(hst_rdata), 0);
    e_write(2, 50); e_commit(); h_read(3);
    h_done();

    // R11: flush mid-packet clears data and flags
    tag = "R11";
    h_write(3, 1); h_commit(); e_write(5, 2);
    set_cfg(1, 1, 1, 0);
    chk("R11", "eng_in_rdy", int'(eng_in_rdy), 0);
    chk("R11", "flags", int'(ovr_flag | und_flag), 0);

    // R12: empty commit, write with commit, done discards rest, read with done
    tag = "R12";
    h_commit();
    chk("R12", "empty commit", int'(eng_in_rdy), 0);
    hst_wr = 1; hst_wdata = 8'd77; hst_commit = 1; step();
    chk("R12", "write+commit", int'(eng_in_rdata), 77);
    e_done();
    e_write(6, 30); e_commit(); e_write(2, 60); e_commit();
    h_read(2); h_done();
    chk("R12", "next pkt head", int'(hst_rdata), 60);
    hst_rd = 1; hst_done = 1; step();

    // R6: random concurrent traffic, split double-buffered both ways
    tag = "R6";
    for (int c = 0; c < 3000; c++) begin
      hst_wr = ($urandom % 3) != 0; hst_wdata = 8'($urandom);
      hst_commit = ($urandom % 40) == 0;
      eng_out_wr = ($urandom % 3) != 0; eng_out_wdata = 8'($urandom);
      eng_out_commit = ($urandom % 40) == 0;
      eng_in_rd = ($urandom % 2) != 0; eng_in_done = ($urandom % 60) == 0;
      hst_rd = ($urandom % 2) != 0; hst_done = ($urandom % 60) == 0;
      step();
    end

    step();
    ended = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule